// File: doc/BRIEF.md
# Two-Wire Bus Activity and Timeout Monitor

This block watches the clock and data lines of a two-wire serial bus and reports activity to a host controller. Both raw line levels are brought into the local clock domain through a synchronizer, then compared with their previous values. A start condition (data falls while clock is high) sets a busy flag. A stop condition (data rises while clock is high) clears it. The busy flag also clears when both lines stay high for longer than a programmed number of ticks from a selectable timer source.

A second counter detects a bus hang in which the clock line is held low. It is reloaded while the clock line is high and counts while it is low. When it wraps, it raises a sticky interrupt that the host clears by writing one. In split mode only the upper half of this counter is held in reload, and the lower half keeps running. The block also forms the event interrupt for the serial engine. Slave events can be masked by an inhibit bit, while master events always pass.

Top module: `smb_line_monitor`

## Requirements
- R1: Under synchronous reset, busy, bus_free, lto_irq and evt_irq are 0, and both synchronized lines read high.
- R2: A falling data edge with the clock high sets busy. Busy shows the change on the third rising clock edge after the raw input changes (two synchronizer stages plus one edge register).
- R3: A rising data edge with the clock high clears busy, with the same latency as R2. Data edges while the clock is low leave busy unchanged.
- R4: With cfg_en at 0, busy is held at 0 from the next edge. No bus_free pulse, no lto_irq set and no evt_irq occur, and the slave mask output is 0.
- R5: tick_src picks the idle-timer tick: 00 selects tick_t0, 01 selects tick_t1, 10 selects tick_t2hi, 11 selects tick_t2lo. Ticks from the other sources have no effect.
- R6: With cfg_free_en set, bus_free pulses for one cycle on the 11th selected tick during which both synchronized lines are high, and busy clears on the same edge. The tick count restarts from zero whenever either line is low. After the pulse the count saturates, so no further pulse occurs until a line goes low.
- R7: With cfg_low_en set and split mode off, the 16-bit counter is loaded with 0xFF00 while the synchronized clock is high and advances by one per cycle while it is low. A wrap from 0xFFFF sets lto_irq. lto_irq stays set until lto_clr is asserted, and a new wrap in the same cycle takes priority over the clear.
- R8: In split mode (cfg_split=1) the low byte advances every cycle regardless of the clock line. The high byte is held at 0xFF while the clock is high. While the clock is low, the high byte advances on each low-byte wrap, and its wrap from 0xFF sets lto_irq.
- R9: evt_irq is registered as cfg_en and (mst_evt or (slv_evt and not cfg_inh)). slv_mask equals cfg_en and cfg_inh.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_in | input | 1 | Raw clock line level |
| sda_in | input | 1 | Raw data line level |
| tick_src | input | 2 | Idle-timer tick source select |
| tick_t0 | input | 1 | Candidate tick, timer 0 overflow |
| tick_t1 | input | 1 | Candidate tick, timer 1 overflow |
| tick_t2hi | input | 1 | Candidate tick, timer 2 upper-byte overflow |
| tick_t2lo | input | 1 | Candidate tick, timer 2 lower-byte overflow |
| cfg_en | input | 1 | Monitor enable |
| cfg_inh | input | 1 | Slave event inhibit |
| cfg_free_en | input | 1 | Idle-high timeout enable |
| cfg_low_en | input | 1 | Clock-low timeout enable |
| cfg_split | input | 1 | Split mode for the low-timeout counter |
| lto_clr | input | 1 | Write-one clear of lto_irq |
| mst_evt | input | 1 | Master event pulse |
| slv_evt | input | 1 | Slave event pulse |
| busy | output | 1 | Transfer in progress |
| bus_free | output | 1 | One-cycle idle-timeout pulse |
| lto_irq | output | 1 | Sticky clock-low timeout interrupt |
| evt_irq | output | 1 | Registered event interrupt |
| slv_mask | output | 1 | Slave events currently masked |

## Verification
The tick sources toggle at different rates, so a miswired selector changes when bus_free fires and is caught on that cycle. An off-by-one in the idle count makes the pulse one tick early or late. A count that fails to saturate gives a second pulse. The split-mode run depends on the phase of the free-running low byte, so a design that also reloads the low byte wraps later and misses the expected cycle. The bench also drives data edges while the clock is low, and line activity while the monitor is disabled. A design that treats the former as start or stop conditions, or that keeps monitoring while disabled, shows a busy flag the model does not have.

// File: rtl/smbmon_pkg.sv
package smbmon_pkg;

    typedef enum logic [1:0] {
        SRC_T0   = 2'b00,
        SRC_T1   = 2'b01,
        SRC_T2HI = 2'b10,
        SRC_T2LO = 2'b11
    } tick_src_e;

    typedef struct packed {
        logic scl;
        logic sda;
    } bus_lines_t;

    typedef struct packed {
        logic start;
        logic stop;
    } bus_cond_t;

    function automatic logic pick_tick(input tick_src_e src, input logic [3:0] ticks);
        logic t;
        case (src)
            SRC_T0:   t = ticks[0];
            SRC_T1:   t = ticks[1];
            SRC_T2HI: t = ticks[2];
            default:  t = ticks[3];
        endcase
        return t;
    endfunction

endpackage

// File: rtl/smbmon_sync.sv
module smbmon_sync
    import smbmon_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  bus_lines_t raw,
    output bus_lines_t synced,
    output bus_lines_t prior
);
    bus_lines_t stage_q [STAGES];

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            always_ff @(posedge clk) begin
                if (rst) begin
                    stage_q[g] <= '1;
                end else if (g == 0) begin
                    stage_q[g] <= raw;
                end else begin
                    stage_q[g] <= stage_q[(g == 0) ? 0 : g - 1];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            prior <= '1;
        end else begin
            prior <= stage_q[STAGES-1];
        end
    end

    assign synced = stage_q[STAGES-1];
endmodule

// File: rtl/smbmon_cond.sv
module smbmon_cond
    import smbmon_pkg::*;
(
    input  bus_lines_t cur,
    input  bus_lines_t prv,
    output bus_cond_t  cond
);
    logic clk_held;

    always_comb begin
        clk_held   = cur.scl & prv.scl;
        cond.start = clk_held & prv.sda & ~cur.sda;
        cond.stop  = clk_held & ~prv.sda & cur.sda;
    end
endmodule

// File: rtl/smbmon_idle.sv
module smbmon_idle #(
    parameter int FREE_TICKS = 10
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    input  logic lines_high,
    input  logic tick,
    output logic free_hit,
    output logic free_pulse
);
    localparam int CW = $clog2(FREE_TICKS + 2);
    localparam logic [CW-1:0] LIMIT = CW'(FREE_TICKS);
    localparam logic [CW-1:0] SAT   = CW'(FREE_TICKS + 1);

    logic [CW-1:0] cnt_q;

    assign free_hit = run & lines_high & tick & (cnt_q == LIMIT);

    always_ff @(posedge clk) begin
        if (rst || !run || !lines_high) begin
            cnt_q <= '0;
        end else if (tick && cnt_q != SAT) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            free_pulse <= 1'b0;
        end else begin
            free_pulse <= free_hit;
        end
    end
endmodule

// File: rtl/smbmon_lowto.sv
module smbmon_lowto #(
    parameter int          W      = 16,
    parameter logic [W-1:0] RELOAD = 16'hFF00
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    input  logic split,
    input  logic scl_high,
    input  logic clr,
    output logic irq
);
    localparam int H = W / 2;
    localparam logic [H-1:0] RLO = RELOAD[H-1:0];
    localparam logic [H-1:0] RHI = RELOAD[W-1:H];

    logic [H-1:0] lo_q, hi_q, lo_d, hi_d;
    logic         ovf;

    always_comb begin
        lo_d = lo_q;
        hi_d = hi_q;
        ovf  = 1'b0;
        if (!run) begin
            lo_d = RLO;
            hi_d = RHI;
        end else if (split) begin
            lo_d = lo_q + 1'b1;
            if (scl_high) begin
                hi_d = RHI;
            end else if (&lo_q) begin
                if (&hi_q) begin
                    ovf  = 1'b1;
                    hi_d = RHI;
                end else begin
                    hi_d = hi_q + 1'b1;
                end
            end
        end else begin
            if (scl_high) begin
                {hi_d, lo_d} = RELOAD;
            end else if (&{hi_q, lo_q}) begin
                ovf           = 1'b1;
                {hi_d, lo_d} = RELOAD;
            end else begin
                {hi_d, lo_d} = {hi_q, lo_q} + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            lo_q <= RLO;
            hi_q <= RHI;
            irq  <= 1'b0;
        end else begin
            lo_q <= lo_d;
            hi_q <= hi_d;
            if (ovf) begin
                irq <= 1'b1;
            end else if (clr) begin
                irq <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/smb_line_monitor.sv
module smb_line_monitor
    import smbmon_pkg::*;
#(
    parameter int              SYNC_STAGES = 2,
    parameter int              FREE_TICKS  = 10,
    parameter int              LT_W        = 16,
    parameter logic [LT_W-1:0] LT_RELOAD   = 16'hFF00
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       scl_in,
    input  logic       sda_in,
    input  logic [1:0] tick_src,
    input  logic       tick_t0,
    input  logic       tick_t1,
    input  logic       tick_t2hi,
    input  logic       tick_t2lo,
    input  logic       cfg_en,
    input  logic       cfg_inh,
    input  logic       cfg_free_en,
    input  logic       cfg_low_en,
    input  logic       cfg_split,
    input  logic       lto_clr,
    input  logic       mst_evt,
    input  logic       slv_evt,
    output logic       busy,
    output logic       bus_free,
    output logic       lto_irq,
    output logic       evt_irq,
    output logic       slv_mask
);
    bus_lines_t raw_lines, cur_lines, prv_lines;
    bus_cond_t  cond;
    logic       sel_tick, free_hit;

    assign raw_lines.scl = scl_in;
    assign raw_lines.sda = sda_in;

    smbmon_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst    (rst),
        .raw    (raw_lines),
        .synced (cur_lines),
        .prior  (prv_lines)
    );

    smbmon_cond u_cond (
        .cur  (cur_lines),
        .prv  (prv_lines),
        .cond (cond)
    );

    assign sel_tick = pick_tick(tick_src_e'(tick_src),
                                {tick_t2lo, tick_t2hi, tick_t1, tick_t0});

    smbmon_idle #(.FREE_TICKS(FREE_TICKS)) u_idle (
        .clk        (clk),
        .rst        (rst),
        .run        (cfg_en & cfg_free_en),
        .lines_high (cur_lines.scl & cur_lines.sda),
        .tick       (sel_tick),
        .free_hit   (free_hit),
        .free_pulse (bus_free)
    );

    smbmon_lowto #(.W(LT_W), .RELOAD(LT_RELOAD)) u_lowto (
        .clk      (clk),
        .rst      (rst),
        .run      (cfg_en & cfg_low_en),
        .split    (cfg_split),
        .scl_high (cur_lines.scl),
        .clr      (lto_clr),
        .irq      (lto_irq)
    );

    always_ff @(posedge clk) begin
        if (rst || !cfg_en) begin
            busy <= 1'b0;
        end else if (cond.start) begin
            busy <= 1'b1;
        end else if (cond.stop || free_hit) begin
            busy <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            evt_irq <= 1'b0;
        end else begin
            evt_irq <= cfg_en & (mst_evt | (slv_evt & ~cfg_inh));
        end
    end

    assign slv_mask = cfg_en & cfg_inh;
endmodule

// File: rtl/smb_line_monitor_chk.sv
module smb_line_monitor_chk (
    input logic clk,
    input logic rst,
    input logic cfg_en,
    input logic cfg_inh,
    input logic lto_clr,
    input logic mst_evt,
    input logic busy,
    input logic bus_free,
    input logic lto_irq,
    input logic evt_irq,
    input logic slv_mask
);
    p_busy_off_r4: assert property (@(posedge clk) disable iff (rst)
        !cfg_en |=> !busy);

    p_free_single_r6: assert property (@(posedge clk) disable iff (rst)
        bus_free |=> !bus_free);

    p_free_not_busy_r6: assert property (@(posedge clk) disable iff (rst)
        bus_free |-> !busy);

    p_lto_sticky_r7: assert property (@(posedge clk) disable iff (rst)
        lto_irq && !lto_clr |=> lto_irq);

    p_slave_blocked_r9: assert property (@(posedge clk) disable iff (rst)
        cfg_en && cfg_inh && !mst_evt |=> !evt_irq);

    p_mask_needs_inh_r9: assert property (@(posedge clk) disable iff (rst)
        slv_mask |-> cfg_inh);
endmodule

bind smb_line_monitor smb_line_monitor_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .cfg_en   (cfg_en),
    .cfg_inh  (cfg_inh),
    .lto_clr  (lto_clr),
    .mst_evt  (mst_evt),
    .busy     (busy),
    .bus_free (bus_free),
    .lto_irq  (lto_irq),
    .evt_irq  (evt_irq),
    .slv_mask (slv_mask)
);

// File: tb/smb_line_monitor_tb_top.sv
`timescale 1ns/1ps
module smb_line_monitor_tb_top;
    localparam int RLO = 'h00;
    localparam int RHI = 'hFF;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic scl_in = 1'b1, sda_in = 1'b1;
    logic [1:0] tick_src = 2'b00;
    logic tick_t0 = 0, tick_t1 = 0, tick_t2hi = 0, tick_t2lo = 0;
    logic cfg_en = 0, cfg_inh = 0, cfg_free_en = 0, cfg_low_en = 0, cfg_split = 0;
    logic lto_clr = 0, mst_evt = 0, slv_evt = 0;
    logic busy, bus_free, lto_irq, evt_irq, slv_mask;
    logic tick_on = 0;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    always #4 clk = ~clk;

    smb_line_monitor dut_i (
        .clk(clk), .rst(rst), .scl_in(scl_in), .sda_in(sda_in),
        .tick_src(tick_src), .tick_t0(tick_t0), .tick_t1(tick_t1),
        .tick_t2hi(tick_t2hi), .tick_t2lo(tick_t2lo),
        .cfg_en(cfg_en), .cfg_inh(cfg_inh), .cfg_free_en(cfg_free_en),
        .cfg_low_en(cfg_low_en), .cfg_split(cfg_split), .lto_clr(lto_clr),
        .mst_evt(mst_evt), .slv_evt(slv_evt),
        .busy(busy), .bus_free(bus_free), .lto_irq(lto_irq),
        .evt_irq(evt_irq), .slv_mask(slv_mask)
    );

    // tick sources at distinct rates
    always @(posedge clk) begin
        #1;
        cyc = cyc + 1;
        tick_t0   <= tick_on && (cyc % 3 == 0);
        tick_t1   <= tick_on && (cyc % 5 == 0);
        tick_t2hi <= tick_on && (cyc % 7 == 0);
        tick_t2lo <= tick_on && (cyc % 2 == 0);
    end

    // behavioural reference: line history, idle count, hang timer
    int h_scl[$], h_sda[$];
    int m_idle, m_lo, m_hi;
    bit m_busy, m_free, m_lto, m_evt;

    always @(posedge clk) begin
        if (rst) begin
            h_scl = '{1, 1, 1}; h_sda = '{1, 1, 1};
            m_idle = 0; m_lo = RLO; m_hi = RHI;
            m_busy = 0; m_free = 0; m_lto = 0; m_evt = 0;
        end else begin
            int s_scl, s_sda, p_scl, p_sda, tk, full;
            bit st, sp, hit, wrap;
            s_scl = h_scl[1]; s_sda = h_sda[1];
            p_scl = h_scl[2]; p_sda = h_sda[2];
            st = s_scl && p_scl && p_sda && !s_sda;
            sp = s_scl && p_scl && !p_sda && s_sda;
            case (tick_src)
                2'b00: tk = tick_t0;
                2'b01: tk = tick_t1;
                2'b10: tk = tick_t2hi;
                default: tk = tick_t2lo;
            endcase
            hit = 0;
            if (!(cfg_en && cfg_free_en) || !(s_scl && s_sda)) begin
                m_idle = 0;
            end else if (tk) begin
                if (m_idle == 10) hit = 1;
                if (m_idle < 11) m_idle++;
            end
            m_free = hit;
            wrap = 0;
            if (!(cfg_en && cfg_low_en)) begin
                m_lo = RLO; m_hi = RHI;
            end else if (cfg_split) begin
                if (s_scl) m_hi = RHI;
                else if (m_lo == 255) begin
                    if (m_hi == 255) begin wrap = 1; m_hi = RHI; end
                    else m_hi++;
                end
                m_lo = (m_lo + 1) % 256;
            end else begin
                full = m_hi * 256 + m_lo;
                if (s_scl) full = RHI * 256 + RLO;
                else if (full == 65535) begin wrap = 1; full = RHI * 256 + RLO; end
                else full++;
                m_hi = full / 256; m_lo = full % 256;
            end
            if (wrap) m_lto = 1;
            else if (lto_clr) m_lto = 0;
            if (!cfg_en) m_busy = 0;
            else if (st) m_busy = 1;
            else if (sp || hit) m_busy = 0;
            m_evt = cfg_en && (mst_evt || (slv_evt && !cfg_inh));
            void'(h_scl.pop_back()); void'(h_sda.pop_back());
            h_scl.push_front(scl_in); h_sda.push_front(sda_in);
        end
    end

    task automatic chk(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0b expected=%0b at cycle %0d", tag, act, exp, cyc);
        end
    endtask

    always @(negedge clk) begin
        if (!rst) begin
            chk("R2/R3/R6 busy", busy, m_busy);
            chk("R5/R6 bus_free", bus_free, m_free);
            chk("R7/R8 lto_irq", lto_irq, m_lto);
            chk("R9 evt_irq", evt_irq, m_evt);
            chk("R9 slv_mask", slv_mask, cfg_en && cfg_inh);
        end
    end

    task automatic go(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic lines(input logic c, input logic d, input int n);
        scl_in = c; sda_in = d;
        go(n);
    endtask

    task automatic frame();
        lines(1, 1, 6);
        lines(1, 0, 6);     // start
        lines(0, 0, 4);
        lines(0, 1, 4);     // data change with clock low
        lines(1, 1, 4);
        lines(0, 1, 4);
        lines(0, 0, 4);
        lines(1, 0, 6);
        lines(1, 1, 6);     // stop
    endtask

    initial begin
        go(4);
        @(negedge clk);
        chk("R1 busy", busy, 1'b0);
        chk("R1 bus_free", bus_free, 1'b0);
        chk("R1 lto_irq", lto_irq, 1'b0);
        chk("R1 evt_irq", evt_irq, 1'b0);
        go(1);
        rst = 0;
        go(2);

        // disabled: nothing reacts
        cfg_low_en = 1; cfg_free_en = 1; tick_on = 1;
        frame();
        lines(1, 0, 4);
        mst_evt = 1; slv_evt = 1; go(2); mst_evt = 0; slv_evt = 0;
        lines(0, 0, 300);
        @(negedge clk);
        chk("R4 busy", busy, 1'b0);
        chk("R4 lto_irq", lto_irq, 1'b0);
        chk("R4 slv_mask", slv_mask, 1'b0);
        go(1);
        lines(1, 1, 4);

        // enabled: start/stop and idle timeout per source
        cfg_en = 1; cfg_low_en = 0;
        frame();
        for (int s = 0; s < 4; s++) begin
            tick_src = 2'(s);
            lines(1, 1, 4);
            lines(1, 0, 8);
            @(negedge clk);
            chk("R2 busy set", busy, 1'b1);
            go(1);
            lines(0, 0, 3);
            lines(1, 0, 3);
            lines(1, 1, 120);
            @(negedge clk);
            chk("R6 busy cleared by idle", busy, 1'b0);
            go(1);
        end
        // idle count restart on a brief low
        tick_src = 2'b00;
        lines(1, 0, 6);
        lines(1, 1, 20);
        lines(0, 1, 2);
        lines(1, 1, 60);

        // hang timer, full width
        cfg_low_en = 1; cfg_free_en = 0;
        lines(0, 0, 300);
        @(negedge clk);
        chk("R7 lto set", lto_irq, 1'b1);
        go(1);
        lines(1, 0, 20);
        @(negedge clk);
        chk("R7 lto sticky", lto_irq, 1'b1);
        go(1);
        lto_clr = 1; go(1); lto_clr = 0;
        lines(0, 0, 100);
        lines(1, 0, 4);
        lines(0, 0, 100);

        // hang timer, split
        cfg_split = 1;
        lines(1, 0, 37);
        lines(0, 0, 300);
        lto_clr = 1; go(1); lto_clr = 0;
        lines(1, 0, 11);
        lines(0, 0, 300);
        @(negedge clk);
        chk("R8 split lto", lto_irq, 1'b1);
        go(1);
        lto_clr = 1; go(1); lto_clr = 0;
        cfg_split = 0; cfg_low_en = 0;

        // events with and without inhibit
        for (int i = 0; i < 2; i++) begin
            cfg_inh = i[0];
            slv_evt = 1; go(1); slv_evt = 0; go(2);
            mst_evt = 1; go(1); mst_evt = 0; go(2);
            slv_evt = 1; mst_evt = 1; go(1); slv_evt = 0; mst_evt = 0; go(2);
        end
        cfg_en = 0; go(3);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL R1 watchdog actual=running expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule